// File: doc/BRIEF.md
# Four-Phase Handshake Event Engine

This block is a small clocked controller that exchanges data with its neighbours over four-phase request/acknowledge channels. It owns two input channels (a data channel A and a token channel B), one output channel with a data register, and a single one-bit occupancy flag. Each clock cycle it evaluates a fixed, prioritised chain of events. Only the first event whose conditions all hold fires. A firing event may acknowledge inputs, raise the output request, load the output register and set or clear the flag.

The built-in event set moves words from A to the output. The first event forwards a word from A when the output is free and the flag is empty, and it fills the flag. The second event accepts a token on B when the flag is full, and it empties the flag. A word from A and a token from B therefore strictly alternate. Each channel completes its return-to-zero phase on its own, so neighbours can run any four-phase timing.

Top module: `hs_event_engine`

## Requirements
- R1: While reset is asserted (rst_n low), a_ack and b_ack are 1, out_req is 0 and out_data is 0.
- R2: An input acknowledge that is 1 returns to 0 on the first rising edge at which that input's request is 0.
- R3: An input request that is still high when reset is released is not consumed: its acknowledge stays 1 until the request has dropped.
- R4: When a_req is 1, a_ack is 0, out_req and out_ack are both 0 and the flag is empty, the next rising edge sets a_ack to 1, sets out_req to 1, loads out_data with a_data and fills the flag.
- R5: Input A is not consumed while the output is busy, that is, while out_req or out_ack is 1.
- R6: When out_req and out_ack are both 1, the next edge clears out_req. With KEEP_DATA=0 it also clears out_data to 0. With KEEP_DATA=1, out_data keeps its value.
- R7: When b_req is 1, b_ack is 0 and the flag is full, the next edge sets b_ack to 1 and empties the flag.
- R8: B is never consumed while the flag is empty, and A is never consumed while the flag is full.
- R9: Parameter INIT_FULL sets the flag value after reset. With INIT_FULL=1, the first event that can fire is the one on B.
- R10: Words appear on out_data in the order they were accepted on A, and out_data is stable while out_req stays high.
- R11: Reset is asynchronous: pulling rst_n low forces the R1 values without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_req | input | 1 | Request of data input A |
| a_data | input | DATA_W | Word offered on input A |
| a_ack | output | 1 | Acknowledge of input A |
| b_req | input | 1 | Request of token input B |
| b_ack | output | 1 | Acknowledge of input B |
| out_req | output | 1 | Request of the output channel |
| out_data | output | DATA_W | Output data register |
| out_ack | input | 1 | Acknowledge from the output's consumer |

## Verification
The occupancy flag has no port of its own, so any error in it shows up in the handshakes. A flag stuck empty makes B hang unacknowledged. A flag stuck full blocks A after the first word. Either case shows at the ports within the one or two cycles after the offending request. A wrong acknowledge register shows one edge after the request changes, as an early consume or a return-to-zero that never happens. A corrupted output register shows in the next word presented with out_req high.

// File: rtl/hs_event_pkg.sv
package hs_event_pkg;
  localparam int unsigned NUM_IN = 2;
  localparam int unsigned IN_A   = 0;
  localparam int unsigned IN_B   = 1;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_FWD_A  = 2'd1,
    EV_TAKE_B = 2'd2
  } ev_sel_e;
endpackage

// File: rtl/hs_in_port.sv
module hs_in_port #(
  parameter bit RESET_ACK = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic take,
  output logic ack,
  output logic ready
);
  logic ack_q, ack_nxt, ack_en;

  always_comb begin
    ack_nxt = ack_q;
    if (take)
      ack_nxt = 1'b1;
    else if (!req && ack_q)
      ack_nxt = 1'b0;
    ack_en = (ack_nxt != ack_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ack_q <= RESET_ACK;
    else if (ack_en)
      ack_q <= ack_nxt;
  end

  assign ack   = ack_q;
  assign ready = req && !ack_q;
endmodule

// File: rtl/hs_out_port.sv
module hs_out_port #(
  parameter int unsigned DATA_W    = 32,
  parameter bit          KEEP_DATA = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit,
  input  logic [DATA_W-1:0] din,
  input  logic              ack,
  output logic              req,
  output logic [DATA_W-1:0] data,
  output logic              free
);
  logic              req_q, req_nxt, req_en;
  logic [DATA_W-1:0] data_q, data_nxt;
  logic              data_en;
  logic              done;

  assign done = req_q && ack;

  always_comb begin
    req_nxt  = req_q;
    data_nxt = data_q;
    data_en  = 1'b0;
    if (emit) begin
      req_nxt  = 1'b1;
      data_nxt = din;
      data_en  = 1'b1;
    end else if (done) begin
      req_nxt = 1'b0;
      if (!KEEP_DATA) begin
        data_nxt = '0;
        data_en  = 1'b1;
      end
    end
    req_en = (req_nxt != req_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      req_q <= 1'b0;
    else if (req_en)
      req_q <= req_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      data_q <= '0;
    else if (data_en)
      data_q <= data_nxt;
  end

  assign req  = req_q;
  assign data = data_q;
  assign free = !req_q && !ack;
endmodule

// File: rtl/hs_state_bit.sv
module hs_state_bit #(
  parameter bit INIT_FULL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fill,
  input  logic drain,
  output logic full
);
  logic full_q, full_nxt, full_en;

  always_comb begin
    full_nxt = full_q;
    if (fill)
      full_nxt = 1'b1;
    else if (drain)
      full_nxt = 1'b0;
    full_en = (full_nxt != full_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      full_q <= INIT_FULL;
    else if (full_en)
      full_q <= full_nxt;
  end

  assign full = full_q;
endmodule

// File: rtl/hs_event_chain.sv
module hs_event_chain
  import hs_event_pkg::*;
(
  input  logic [NUM_IN-1:0] in_ready,
  input  logic              out_free,
  input  logic              flag_full,
  output ev_sel_e           sel
);
  // First match wins; later entries are only tested when earlier ones fail.
  always_comb begin
    if (in_ready[IN_A] && out_free && !flag_full)
      sel = EV_FWD_A;
    else if (in_ready[IN_B] && flag_full)
      sel = EV_TAKE_B;
    else
      sel = EV_NONE;
  end
endmodule

// File: rtl/hs_event_engine.sv
module hs_event_engine
  import hs_event_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter bit          INIT_FULL = 1'b0,
  parameter bit          KEEP_DATA = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_req,
  input  logic [DATA_W-1:0] a_data,
  output logic              a_ack,
  input  logic              b_req,
  output logic              b_ack,
  output logic              out_req,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ack
);
  logic [NUM_IN-1:0] in_req, in_ack, in_ready, in_take;
  logic              out_free, emit, fill, drain, flag_full;
  ev_sel_e           sel;

  assign in_req[IN_A] = a_req;
  assign in_req[IN_B] = b_req;

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
    hs_in_port #(.RESET_ACK(1'b1)) u_in (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (in_req[gi]),
      .take  (in_take[gi]),
      .ack   (in_ack[gi]),
      .ready (in_ready[gi])
    );
  end

  hs_event_chain u_chain (
    .in_ready  (in_ready),
    .out_free  (out_free),
    .flag_full (flag_full),
    .sel       (sel)
  );

  always_comb begin
    in_take = '0;
    emit    = 1'b0;
    fill    = 1'b0;
    drain   = 1'b0;
    unique case (sel)
      EV_FWD_A: begin
        in_take[IN_A] = 1'b1;
        emit          = 1'b1;
        fill          = 1'b1;
      end
      EV_TAKE_B: begin
        in_take[IN_B] = 1'b1;
        drain         = 1'b1;
      end
      default: ;
    endcase
  end

  hs_out_port #(.DATA_W(DATA_W), .KEEP_DATA(KEEP_DATA)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .emit  (emit),
    .din   (a_data),
    .ack   (out_ack),
    .req   (out_req),
    .data  (out_data),
    .free  (out_free)
  );

  hs_state_bit #(.INIT_FULL(INIT_FULL)) u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .fill  (fill),
    .drain (drain),
    .full  (flag_full)
  );

  assign a_ack = in_ack[IN_A];
  assign b_ack = in_ack[IN_B];
endmodule

// File: rtl/hs_event_engine_checker.sv
module hs_event_engine_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_req,
  input logic              a_ack,
  input logic              b_req,
  input logic              b_ack,
  input logic              out_req,
  input logic              out_ack,
  input logic [DATA_W-1:0] out_data,
  input logic              flag_full
);
  // R4: A is acknowledged only while its request is up
  assert_a_ack_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_ack) |-> $past(a_req));
  // R2: acknowledges drop only after the request has dropped
  assert_a_ack_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(a_ack) |-> !$past(a_req));
  assert_b_ack_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(b_ack) |-> !$past(b_req));
  // R5: the output request rises only after the previous cycle's ack is gone
  assert_out_req_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_req) |-> !$past(out_ack));
  // R6: the output request falls only on an acknowledge
  assert_out_req_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_req) |-> $past(out_ack));
  // R10: data held while the request stays high
  assert_out_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && $past(out_req)) |-> $stable(out_data));
  // R4: the flag fills together with a new output word
  assert_flag_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_full) |-> ($rose(out_req) && $rose(a_ack)));
  // R7: the flag empties together with a B acknowledge
  assert_flag_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_full) |-> $rose(b_ack));
  // R8: B taken only while the flag was full
  assert_b_needs_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_ack) |-> $past(flag_full));
endmodule

bind hs_event_engine hs_event_engine_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .a_req     (a_req),
  .a_ack     (a_ack),
  .b_req     (b_req),
  .b_ack     (b_ack),
  .out_req   (out_req),
  .out_ack   (out_ack),
  .out_data  (out_data),
  .flag_full (flag_full)
);

// File: tb/hs_event_engine_bench.sv
module hs_event_engine_bench;
  localparam int unsigned DW = 32;
  localparam int unsigned NVEC = 8;
  localparam logic [DW-1:0] VEC [NVEC] = '{
    32'hDEAD_BEEF, 32'h0000_0001, 32'hFFFF_FFFF, 32'h1234_5678,
    32'h8000_0000, 32'h5A5A_A5A5, 32'h0F0F_F0F0, 32'hCAFE_0042
  };

  logic clk = 1'b0;
  logic rst_n;
  logic a_req, b_req, out_ack;
  logic [DW-1:0] a_data;
  logic a_ack, b_ack, out_req;
  logic [DW-1:0] out_data;
  // second instance: flag starts full, data kept after completion
  logic f_a_req, f_b_req, f_out_ack;
  logic [DW-1:0] f_a_data;
  logic f_a_ack, f_b_ack, f_out_req;
  logic [DW-1:0] f_out_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hs_event_engine #(.DATA_W(DW)) u_hs_event_engine (
    .clk(clk), .rst_n(rst_n), .a_req(a_req), .a_data(a_data), .a_ack(a_ack),
    .b_req(b_req), .b_ack(b_ack), .out_req(out_req), .out_data(out_data),
    .out_ack(out_ack));

  hs_event_engine #(.DATA_W(DW), .INIT_FULL(1'b1), .KEEP_DATA(1'b1)) u_full (
    .clk(clk), .rst_n(rst_n), .a_req(f_a_req), .a_data(f_a_data), .a_ack(f_a_ack),
    .b_req(f_b_req), .b_ack(f_b_ack), .out_req(f_out_req), .out_data(f_out_data),
    .out_ack(f_out_ack));

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // one full word on A, consumer answers after lat cycles
  task automatic word_a(input logic [DW-1:0] d, input int lat);
    a_data = d; a_req = 1'b1;
    tick(1);
    check(a_ack && out_req, "R4 a_ack/out_req", {30'd0, a_ack, out_req}, 32'd3);
    check(out_data == d, "R10 out_data order", out_data, d);
    a_req = 1'b0;
    tick(1);
    check(!a_ack, "R2 a_ack return", {31'd0, a_ack}, 32'd0);
    tick(lat);
    check(out_data == d, "R10 out_data held", out_data, d);
    out_ack = 1'b1;
    tick(1);
    check(!out_req && out_data == '0, "R6 completion clears", out_data, 32'd0);
    out_ack = 1'b0;
    tick(1);
  endtask

  task automatic token_b();
    b_req = 1'b1;
    tick(1);
    check(b_ack, "R7 b_ack", {31'd0, b_ack}, 32'd1);
    b_req = 1'b0;
    tick(1);
    check(!b_ack, "R2 b_ack return", {31'd0, b_ack}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; a_req = 1'b1; b_req = 1'b0; out_ack = 1'b0; a_data = 32'h1111_1111;
    f_a_req = 1'b0; f_b_req = 1'b0; f_out_ack = 1'b0; f_a_data = '0;
    tick(3);
    // R1: reset values
    check(a_ack && b_ack && !out_req && out_data == '0, "R1 reset state",
          {29'd0, a_ack, b_ack, out_req}, 32'd6);
    rst_n = 1'b1;
    tick(2);
    // R3: stale request across reset not consumed
    check(a_ack && !out_req, "R3 held request ignored", {30'd0, a_ack, out_req}, 32'd2);
    a_req = 1'b0;
    tick(1);
    check(!a_ack && !b_ack, "R2 acks return after reset", {30'd0, a_ack, b_ack}, 32'd0);

    // vector table: words and tokens alternate, varying consumer latency
    for (int i = 0; i < NVEC; i++) begin
      word_a(VEC[i], i % 3);
      token_b();
    end

    // R8: B waits while the flag is empty, fires once A fills it
    b_req = 1'b1;
    tick(2);
    check(!b_ack, "R8 B blocked on empty flag", {31'd0, b_ack}, 32'd0);
    a_data = 32'hA5A5_0001; a_req = 1'b1;
    tick(1);
    check(a_ack && out_req && !b_ack, "R4 A fires before B",
          {29'd0, a_ack, out_req, b_ack}, 32'd6);
    a_req = 1'b0;
    tick(1);
    check(b_ack, "R7 B fires after fill", {31'd0, b_ack}, 32'd1);
    b_req = 1'b0;
    // output still busy: A must wait even with flag empty (R5)
    tick(1);
    a_data = 32'hA5A5_0002; a_req = 1'b1;
    tick(2);
    check(!a_ack && out_data == 32'hA5A5_0001, "R5 A blocked by busy output",
          out_data, 32'hA5A5_0001);
    out_ack = 1'b1;
    tick(1);
    check(!out_req && !a_ack, "R5 A blocked while out_ack high",
          {30'd0, out_req, a_ack}, 32'd0);
    out_ack = 1'b0;
    tick(1);
    check(a_ack && out_data == 32'hA5A5_0002, "R5 A fires once output free",
          out_data, 32'hA5A5_0002);
    a_req = 1'b0;
    out_ack = 1'b1;
    tick(1);
    out_ack = 1'b0;
    // R8: A blocked while flag full
    tick(1);
    a_data = 32'hA5A5_0003; a_req = 1'b1;
    tick(2);
    check(!a_ack && !out_req, "R8 A blocked on full flag", {30'd0, a_ack, out_req}, 32'd0);
    b_req = 1'b1;
    tick(1);
    check(b_ack && !a_ack, "R7 B drains first", {30'd0, b_ack, a_ack}, 32'd2);
    b_req = 1'b0;
    tick(1);
    check(a_ack && out_data == 32'hA5A5_0003, "R8 A after drain", out_data, 32'hA5A5_0003);
    a_req = 1'b0;

    // R9 / R6 keep-data variant
    f_a_data = 32'h7777_0001; f_a_req = 1'b1;
    tick(2);
    check(!f_a_ack, "R9 A blocked on initially full flag", {31'd0, f_a_ack}, 32'd0);
    f_b_req = 1'b1;
    tick(1);
    check(f_b_ack, "R9 B first with INIT_FULL", {31'd0, f_b_ack}, 32'd1);
    f_b_req = 1'b0;
    tick(1);
    check(f_a_ack && f_out_req, "R9 A after first token", {30'd0, f_a_ack, f_out_req}, 32'd3);
    f_a_req = 1'b0; f_out_ack = 1'b1;
    tick(1);
    check(!f_out_req && f_out_data == 32'h7777_0001, "R6 KEEP_DATA holds word",
          f_out_data, 32'h7777_0001);
    f_out_ack = 1'b0;

    // R11: asynchronous reset, checked between edges
    tick(1);
    out_ack = 1'b0; a_data = 32'hBEEF_0000; a_req = 1'b1;
    tick(1);
    a_req = 1'b0;
    #2;
    rst_n = 1'b0;
    #1;
    check(a_ack && b_ack && !out_req && out_data == '0, "R11 async reset",
          out_data, 32'd0);
    tick(1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule